// File: doc/BRIEF.md
# Complementary Rectifier Gate Sequencer

This block turns a digitised PWM level into two gate commands for a pair of synchronous rectifier switches. The forward gate is high while PWM is high and the freewheeling gate is high while PWM is low. Neither gate may rise until the other gate has been low for a dead-time gap. A gate that has just fallen must also stay low for a minimum off time before it may rise again.

The minimum off time is normally a short fixed count of clock ticks. While the edge blanking window of the matching PWM edge is active, it becomes a longer count chosen from the configured nominal switching period. A single enable input forces both gates low; it carries the combined undervoltage, fault and soft-start state. During pre-bias startup, a permit input from the startup controller limits when the freewheeling gate may be high. A rise request that arrives while a timer is still running is held back until the timer allows it. It is never lost.

Top module: `rect_gate_seq`

## Requirements
- R1: While `rst_n` is low, `gate_fwd` and `gate_fw` are both 0.
- R2: With `run_en`=1, `gate_fwd` takes the value of `pwm_in` one clock edge later, once the dead-time and minimum off conditions are met. It falls on the first edge after `pwm_in` goes low.
- R3: With `run_en`=1 and `fw_permit`=1, `gate_fw` is the complement of `pwm_in`, with the same latency and timer conditions as R2.
- R4: `gate_fwd` and `gate_fw` are never both 1 in the same cycle.
- R5: A gate rises no earlier than the edge after the one on which the other gate fell. Both gates are therefore low for at least DEAD_TICKS (1) cycle.
- R6: Outside blanking, each gate stays low for at least MINOFF_SHORT (8) cycles before it rises again. A waiting request rises after exactly 8 low cycles.
- R7: `blank_fall`=1 stretches the minimum off time of `gate_fwd`, and `blank_rise`=1 stretches that of `gate_fw`. The stretched value is 30 cycles if `nom_period` >= 600, 15 cycles if 150 <= `nom_period` < 600, and 8 cycles if `nom_period` < 150. The blanking flag of the other gate has no effect.
- R8: `run_en`=0 drives both gates to 0 on the next clock edge.
- R9: `gate_fw` is 0 on the edge after any cycle in which `fw_permit` is 0.
- R10: A rise request that is still present when its timer expires produces the rise; the request is not dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Digitised PWM level |
| nom_period | input | PER_W (11) | Configured nominal switching period in ticks |
| blank_rise | input | 1 | Rising-edge blanking window active |
| blank_fall | input | 1 | Falling-edge blanking window active |
| run_en | input | 1 | Global enable; 0 forces both gates low |
| fw_permit | input | 1 | Freewheel permit window from startup control |
| gate_fwd | output | 1 | Forward rectifier gate command |
| gate_fw | output | 1 | Freewheeling rectifier gate command |

## Verification
Both gates are registered, so every input change shows up on the gates one clock edge later. Inputs are driven at a falling edge and the outputs are sampled at the next falling edge. A dead-time rise of the opposite gate comes one further edge after a gate falls. The bench checks both of those cycles separately. Minimum off times are measured by counting the falling-edge samples in which a gate stays low between its fall and its rise, with the request held throughout. The count must equal the limit exactly, not merely reach it.

// File: rtl/rect_gate_seq.sv
module rect_gate_seq #(
  parameter int PER_W        = 11,
  parameter int DEAD_TICKS   = 1,
  parameter int MINOFF_SHORT = 8,
  parameter int MINOFF_MID   = 15,
  parameter int MINOFF_LONG  = 30,
  parameter int PER_MID_MIN  = 150,
  parameter int PER_LONG_MIN = 600
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_in,
  input  logic [PER_W-1:0] nom_period,
  input  logic             blank_rise,
  input  logic             blank_fall,
  input  logic             run_en,
  input  logic             fw_permit,
  output logic             gate_fwd,
  output logic             gate_fw
);
  localparam int LC_W = $clog2(MINOFF_LONG + 1) + 1;
  localparam logic [LC_W-1:0] LC_MAX = '1;

  logic [1:0]      g, req, blank, may_rise;
  logic [LC_W-1:0] lc [2];
  logic [LC_W-1:0] lim_long;
  logic [LC_W-1:0] lim [2];

  assign lim_long = (nom_period >= PER_W'(PER_LONG_MIN)) ? LC_W'(MINOFF_LONG) :
                    (nom_period >= PER_W'(PER_MID_MIN))  ? LC_W'(MINOFF_MID)  :
                                                           LC_W'(MINOFF_SHORT);

  assign req[0] = run_en & pwm_in;
  assign req[1] = run_en & ~pwm_in & fw_permit;
  assign blank  = {blank_rise, blank_fall};

  // lc counts completed low cycles; +1 includes the cycle ending at this edge
  always_comb begin
    for (int i = 0; i < 2; i++) begin
      lim[i] = blank[i] ? lim_long : LC_W'(MINOFF_SHORT);
      may_rise[i] = ({1'b0, lc[i]} + (LC_W+1)'(1) >= {1'b0, lim[i]}) &&
                    !g[1-i] &&
                    ({1'b0, lc[1-i]} + (LC_W+1)'(1) >= (LC_W+1)'(DEAD_TICKS));
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rst_n) begin
        g[i]  <= 1'b0;
        lc[i] <= LC_MAX;
      end else begin
        g[i]  <= req[i] & (g[i] | may_rise[i]);
        lc[i] <= g[i] ? '0 : ((lc[i] == LC_MAX) ? lc[i] : lc[i] + 1'b1);
      end
    end
  end

  assign gate_fwd = g[0];
  assign gate_fw  = g[1];
endmodule

// File: rtl/rect_gate_seq_chk.sv
module rect_gate_seq_chk #(
  parameter int MINOFF_SHORT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic pwm_in,
  input logic run_en,
  input logic fw_permit,
  input logic gate_fwd,
  input logic gate_fw
);
  localparam int CW = $clog2(MINOFF_SHORT + 1) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] low_f, low_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_f <= CMAX;
      low_w <= CMAX;
    end else begin
      low_f <= gate_fwd ? '0 : ((low_f == CMAX) ? low_f : low_f + 1'b1);
      low_w <= gate_fw  ? '0 : ((low_w == CMAX) ? low_w : low_w + 1'b1);
    end
  end

  p_fwd_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_in |=> !gate_fwd);
  p_fw_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_in |=> !gate_fw);
  p_never_both_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_fwd && gate_fw));
  p_dead_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_fwd) |-> $past(!gate_fw));
  p_dead_fw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_fw) |-> $past(!gate_fwd));
  p_minoff_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_fwd) |-> (low_f >= CW'(MINOFF_SHORT)));
  p_minoff_fw_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_fw) |-> (low_w >= CW'(MINOFF_SHORT)));
  p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!gate_fwd && !gate_fw));
  p_permit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fw_permit |=> !gate_fw);
endmodule

bind rect_gate_seq rect_gate_seq_chk #(.MINOFF_SHORT(MINOFF_SHORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .run_en(run_en),
  .fw_permit(fw_permit), .gate_fwd(gate_fwd), .gate_fw(gate_fw)
);

// File: tb/sim_rect_gate_seq.sv
module sim_rect_gate_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwm_in = 1'b1;
  logic [10:0] nom_period = 11'd222;
  logic        blank_rise = 1'b0;
  logic        blank_fall = 1'b0;
  logic        run_en = 1'b1;
  logic        fw_permit = 1'b1;
  logic        gate_fwd, gate_fw;

  int checks = 0;
  int errors = 0;
  int both_high = 0;

  // bits: [4] pwm, [3] run_en, [2] permit, [1] expected fwd, [0] expected fw
  localparam logic [4:0] VEC [8] = '{5'b11110, 5'b01101, 5'b01000, 5'b11010,
                                     5'b10100, 5'b00100, 5'b01101, 5'b11110};

  rect_gate_seq u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .nom_period(nom_period),
    .blank_rise(blank_rise), .blank_fall(blank_fall), .run_en(run_en),
    .fw_permit(fw_permit), .gate_fwd(gate_fwd), .gate_fw(gate_fw)
  );

  always #2 clk = ~clk;

  always @(negedge clk) if (rst_n && gate_fwd && gate_fw) both_high++;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure_fwd(input logic bf, input logic br, input int per, output int n);
    pwm_in = 1'b1; run_en = 1'b1; blank_fall = 1'b0; blank_rise = 1'b0;
    hold(40);
    blank_fall = bf; blank_rise = br; nom_period = 11'(per);
    pwm_in = 1'b0;
    @(negedge clk);
    pwm_in = 1'b1;
    n = 0;
    while (!gate_fwd && n < 200) begin
      n++;
      @(negedge clk);
    end
    blank_fall = 1'b0; blank_rise = 1'b0;
  endtask

  task automatic measure_fw(input logic bf, input logic br, input int per, output int n);
    pwm_in = 1'b0; run_en = 1'b1; fw_permit = 1'b1; blank_fall = 1'b0; blank_rise = 1'b0;
    hold(40);
    blank_fall = bf; blank_rise = br; nom_period = 11'(per);
    pwm_in = 1'b1;
    @(negedge clk);
    pwm_in = 1'b0;
    n = 0;
    while (!gate_fw && n < 200) begin
      n++;
      @(negedge clk);
    end
    blank_fall = 1'b0; blank_rise = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    hold(4);
    chk("R1 fwd in reset", gate_fwd, 0);
    chk("R1 fw in reset", gate_fw, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 8; k++) begin
      string tag;
      pwm_in = VEC[k][4]; run_en = VEC[k][3]; fw_permit = VEC[k][2];
      hold(40);
      if (!VEC[k][3])      tag = "R8 table";
      else if (VEC[k][4])  tag = "R2 table";
      else if (!VEC[k][2]) tag = "R9 table";
      else                 tag = "R3 table";
      chk({tag, " fwd"}, gate_fwd, int'(VEC[k][1]));
      chk({tag, " fw"},  gate_fw,  int'(VEC[k][0]));
    end

    // R5: dead-time gap of one cycle
    pwm_in = 1'b1; run_en = 1'b1; fw_permit = 1'b1;
    hold(40);
    pwm_in = 1'b0;
    @(negedge clk);
    chk("R5 fwd fell", gate_fwd, 0);
    chk("R5 fw held during gap", gate_fw, 0);
    @(negedge clk);
    chk("R5 fw rises after gap", gate_fw, 1);

    measure_fwd(1'b0, 1'b0, 222, n);  chk("R6 fwd short min off", n, 8);
    chk("R10 fwd delayed rise kept", gate_fwd, 1);
    measure_fw(1'b0, 1'b0, 222, n);   chk("R6 fw short min off", n, 8);
    chk("R10 fw delayed rise kept", gate_fw, 1);
    measure_fwd(1'b1, 1'b0, 1000, n); chk("R7 fwd blank per 1000", n, 30);
    measure_fwd(1'b1, 1'b0, 600, n);  chk("R7 fwd blank per 600", n, 30);
    measure_fwd(1'b1, 1'b0, 599, n);  chk("R7 fwd blank per 599", n, 15);
    measure_fwd(1'b1, 1'b0, 222, n);  chk("R7 fwd blank per 222", n, 15);
    measure_fwd(1'b1, 1'b0, 150, n);  chk("R7 fwd blank per 150", n, 15);
    measure_fwd(1'b1, 1'b0, 149, n);  chk("R7 fwd blank per 149", n, 8);
    measure_fwd(1'b1, 1'b0, 83, n);   chk("R7 fwd blank per 83", n, 8);
    measure_fwd(1'b0, 1'b1, 1000, n); chk("R7 fwd ignores rise blank", n, 8);
    measure_fw(1'b0, 1'b1, 222, n);   chk("R7 fw blank per 222", n, 15);
    measure_fw(1'b1, 1'b0, 1000, n);  chk("R7 fw ignores fall blank", n, 8);

    // R8: disable while forward gate is high
    pwm_in = 1'b1; run_en = 1'b1;
    hold(40);
    run_en = 1'b0;
    @(negedge clk);
    chk("R8 fwd forced low", gate_fwd, 0);
    chk("R8 fw forced low", gate_fw, 0);
    run_en = 1'b1;

    // R9: permit withdrawn while freewheel gate is high
    pwm_in = 1'b0; fw_permit = 1'b1;
    hold(40);
    fw_permit = 1'b0;
    @(negedge clk);
    chk("R9 fw dropped by permit", gate_fw, 0);
    chk("R9 fwd stays low", gate_fwd, 0);
    fw_permit = 1'b1;
    hold(10);

    chk("R4 both-high cycles", both_high, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule